// File: doc/BRIEF.md
# Passive LCD Panel Timing Generator

This block produces the scan timing for a single-panel, 8-bit-wide color passive LCD. It runs entirely on the memory clock. A clock-enable divider sets the pixel timing slot Ts to one, two, three or four memory clocks. A four-state line machine then walks each line through fixed and programmable segments. From that walk the block derives the line pulse, the shift clock, the frame marker and the AC-bias toggle (MOD). While the shift clock runs, it pulls one byte per shift clock from a ready/valid stream and presents that byte as two 4-bit nibbles.

The horizontal geometry comes from two fields in 8-pixel units: a 7-bit display width and a 5-bit non-display width. A fixed overhead of 33 Ts is added to them. The vertical line count sets how many lines make up a frame. Each line is measured from the trailing edge of the line pulse. The machine passes through `ST_LEAD` (52 Ts, where frame and MOD change), `ST_ACTIVE` (shift clock running, (HD+1)*8 Ts), `ST_BLANK` ((HN'+1)*8 - 28 Ts, with HN' = max(HN,3)) and `ST_LPULSE` (9 Ts, line pulse high). The transitions are LEAD_DONE (to ACTIVE), DATA_DONE (to BLANK), BLANK_DONE (to LPULSE) and PULSE_DONE (back to LEAD). PULSE_DONE also advances the line counter, which wraps after the last line.

If the stream has no byte ready when the machine needs one, the block sends a zero byte and sets a sticky underrun flag.

Top module: `pslcd_timing`

## Requirements
- R1: One Ts lasts div_sel+1 memory clocks. The shift clock has a period of 2 Ts, high for 1 Ts and low for 1 Ts.
- R2: One line lasts (HD+1)*8 + (HN'+1)*8 + 33 Ts, where HD is cfg_hdisp and HN' is the effective non-display field.
- R3: A cfg_hblank value below 3 behaves exactly like 3, so HN' = max(cfg_hblank, 3).
- R4: The line pulse lcd_line stays high for 9 Ts once per line.
- R5: The shift clock gives (HD+1)*4 rising edges per line. It stays low during the line pulse. Its last falling edge comes (HN'+1)*8 - 28 Ts before the line pulse rises.
- R6: Each shift clock carries one stream byte: bits 7:4 go on lcd_dup and bits 3:0 on lcd_dlo. The byte changes with the shift clock's rise and is stable across its fall. pix_ready is high for one memory clock per shift clock and at no other time, so the number of ready clocks per line equals the number of shift clocks.
- R7: lcd_frame is high for exactly one line period, once every cfg_vlines+1 lines. Both of its edges come 14 Ts after a line pulse trailing edge.
- R8: lcd_mod toggles once per frame, while lcd_frame is high. The toggle comes (HD+1)*8 + (HN'+1)*8 - 1 Ts before the next line pulse trailing edge.
- R9: If pix_valid is low when a byte is taken, the byte sent is zero and underrun goes high. underrun stays high until reset.
- R10: While rst is high, all outputs are low and all counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div_sel | input | 2 | Ts divide select: Ts = (value+1) clocks |
| cfg_hdisp | input | 7 | Display width in 8-pixel units, minus one |
| cfg_hblank | input | 5 | Non-display width in 8-pixel units, minus one (minimum 3 applied) |
| cfg_vlines | input | 9 | Lines per frame, minus one |
| pix_data | input | 8 | Pixel byte from the stream |
| pix_valid | input | 1 | Stream byte available |
| pix_ready | output | 1 | Byte taken this clock |
| lcd_frame | output | 1 | Frame marker |
| lcd_line | output | 1 | Line pulse |
| lcd_shift | output | 1 | Shift clock |
| lcd_mod | output | 1 | AC-bias toggle |
| lcd_dup | output | 4 | Upper data nibble |
| lcd_dlo | output | 4 | Lower data nibble |
| underrun | output | 1 | Sticky stream-starvation flag |

## Verification
The hardest cases to reach from the ports are the relations between events that are a whole line or a whole frame apart. Examples are the MOD toggle measured against the trailing edge of a later line pulse, and the frame-to-frame spacing. These only show up after several full lines at each divide setting.

The stimulus steps through a table of geometries that covers every divide select, the clamped non-display case and a wide non-display field. A monitor timestamps every edge in memory clocks, so each spacing can be compared with its Ts formula scaled by the divide factor. Starvation is produced by holding pix_valid low through whole lines and then restoring it, which shows that the flag stays set until reset.

// File: rtl/pslcd_pkg.sv
package pslcd_pkg;

    typedef enum logic [1:0] {
        ST_LEAD,
        ST_ACTIVE,
        ST_BLANK,
        ST_LPULSE
    } line_state_t;

    // Segment lengths and event offsets, all in Ts
    localparam int LEAD_TS     = 52;
    localparam int LPULSE_TS   = 9;
    localparam int OVERHEAD_TS = 33;
    localparam int FRAME_OFS   = 14;
    localparam int MOD_OFS     = 34;
    localparam int HN_MIN      = 3;
    localparam int BLANK_TRIM  = LEAD_TS + LPULSE_TS - OVERHEAD_TS;

endpackage

// File: rtl/pslcd_ts_div.sv
module pslcd_ts_div #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_sel,
    output logic             ts_en
);

    logic [DIV_W-1:0] div_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
        end else if (div_cnt >= div_sel) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign ts_en = !rst && (div_cnt >= div_sel);

    // a slot strobe is never followed directly by another unless dividing by one
    AST_TS_GAP: assert property (@(posedge clk) disable iff (rst)
        (ts_en && div_sel != '0) |=> (!ts_en || div_sel == '0)); // R1

endmodule

// File: rtl/pslcd_line_fsm.sv
module pslcd_line_fsm
    import pslcd_pkg::*;
#(
    parameter int HD_W  = 7,
    parameter int HN_W  = 5,
    parameter int VD_W  = 9,
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ts_en,
    input  logic [HD_W-1:0]  hdisp,
    input  logic [HN_W-1:0]  hblank,
    input  logic [VD_W-1:0]  vlines,
    output line_state_t      state,
    output logic [CNT_W-1:0] seg_cnt,
    output logic [VD_W-1:0]  vcnt
);

    logic [HN_W-1:0]  hn_eff;
    logic [CNT_W-1:0] act_last;
    logic [CNT_W-1:0] blank_last;
    logic [CNT_W-1:0] seg_last;
    logic             seg_end;
    line_state_t      st_nxt;

    always_comb begin
        hn_eff     = (hblank < HN_W'(HN_MIN)) ? HN_W'(HN_MIN) : hblank;
        act_last   = ((CNT_W'(hdisp) + 1'b1) << 3) - 1'b1;
        blank_last = ((CNT_W'(hn_eff) + 1'b1) << 3) - CNT_W'(BLANK_TRIM) - 1'b1;
    end

    always_comb begin
        unique case (state)
            ST_LEAD:   begin seg_last = CNT_W'(LEAD_TS - 1);   st_nxt = ST_ACTIVE; end
            ST_ACTIVE: begin seg_last = act_last;              st_nxt = ST_BLANK;  end
            ST_BLANK:  begin seg_last = blank_last;            st_nxt = ST_LPULSE; end
            ST_LPULSE: begin seg_last = CNT_W'(LPULSE_TS - 1); st_nxt = ST_LEAD;   end
            default:   begin seg_last = '0;                    st_nxt = ST_LEAD;   end
        endcase
    end

    assign seg_end = (seg_cnt == seg_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_LEAD;
            seg_cnt <= '0;
            vcnt    <= '0;
        end else if (ts_en) begin
            if (seg_end) begin
                state   <= st_nxt;
                seg_cnt <= '0;
                if (state == ST_LPULSE) begin
                    vcnt <= (vcnt >= vlines) ? '0 : vcnt + 1'b1;
                end
            end else begin
                seg_cnt <= seg_cnt + 1'b1;
            end
        end
    end

    AST_LPULSE_LEN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LPULSE) |-> (seg_cnt < CNT_W'(LPULSE_TS))); // R4

    AST_BLANK_EXIT: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_BLANK && state != ST_BLANK) |-> (state == ST_LPULSE)); // R2

    AST_LEAD_LEN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LEAD) |-> (seg_cnt < CNT_W'(LEAD_TS))); // R2

endmodule

// File: rtl/pslcd_out.sv
module pslcd_out
    import pslcd_pkg::*;
#(
    parameter int VD_W  = 9,
    parameter int CNT_W = 11,
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ts_en,
    input  line_state_t      state,
    input  logic [CNT_W-1:0] seg_cnt,
    input  logic [VD_W-1:0]  vcnt,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             pix_valid,
    output logic             pix_ready,
    output logic             frame_q,
    output logic             line_q,
    output logic             shift_q,
    output logic             mod_q,
    output logic [PIX_W-1:0] data_q,
    output logic             underrun_q
);

    logic take_slot;
    logic at_frame_pt;
    logic at_mod_pt;

    assign take_slot   = ts_en && (state == ST_ACTIVE) && seg_cnt[0];
    assign at_frame_pt = (state == ST_LEAD) && (seg_cnt == CNT_W'(FRAME_OFS));
    assign at_mod_pt   = (state == ST_LEAD) && (seg_cnt == CNT_W'(MOD_OFS)) && (vcnt == '0);
    assign pix_ready   = take_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q    <= 1'b0;
            line_q     <= 1'b0;
            shift_q    <= 1'b0;
            mod_q      <= 1'b0;
            data_q     <= '0;
            underrun_q <= 1'b0;
        end else if (ts_en) begin
            line_q  <= (state == ST_LPULSE);
            shift_q <= (state == ST_ACTIVE) && seg_cnt[0];
            if (at_frame_pt) begin
                frame_q <= (vcnt == '0);
            end
            if (at_mod_pt) begin
                mod_q <= ~mod_q;
            end
            if (take_slot) begin
                data_q <= pix_valid ? pix_data : '0;
                if (!pix_valid) begin
                    underrun_q <= 1'b1;
                end
            end else if (state == ST_LPULSE) begin
                data_q <= '0;
            end
        end
    end

    AST_READY_SHIFT_LOW: assert property (@(posedge clk) disable iff (rst)
        pix_ready |-> !shift_q); // R6

    AST_SHIFT_IDLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        line_q |-> !shift_q); // R5

    AST_DATA_HOLD_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(shift_q) |-> $stable(data_q)); // R6

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(underrun_q) |-> underrun_q); // R9

    AST_MOD_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        ($rose(mod_q) || $fell(mod_q)) |-> frame_q); // R8

endmodule

// File: rtl/pslcd_timing.sv
module pslcd_timing
    import pslcd_pkg::*;
#(
    parameter int DIV_W = 2,
    parameter int HD_W  = 7,
    parameter int HN_W  = 5,
    parameter int VD_W  = 9,
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] cfg_div_sel,
    input  logic [HD_W-1:0]  cfg_hdisp,
    input  logic [HN_W-1:0]  cfg_hblank,
    input  logic [VD_W-1:0]  cfg_vlines,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             pix_valid,
    output logic             pix_ready,
    output logic             lcd_frame,
    output logic             lcd_line,
    output logic             lcd_shift,
    output logic             lcd_mod,
    output logic [PIX_W/2-1:0] lcd_dup,
    output logic [PIX_W/2-1:0] lcd_dlo,
    output logic             underrun
);

    localparam int NIB_W = PIX_W / 2;
    localparam int CNT_W = ((HD_W > HN_W) ? HD_W : HN_W) + 4;

    logic             ts_en;
    line_state_t      state;
    logic [CNT_W-1:0] seg_cnt;
    logic [VD_W-1:0]  vcnt;
    logic [PIX_W-1:0] data_q;

    pslcd_ts_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .div_sel (cfg_div_sel),
        .ts_en   (ts_en)
    );

    pslcd_line_fsm #(
        .HD_W  (HD_W),
        .HN_W  (HN_W),
        .VD_W  (VD_W),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ts_en   (ts_en),
        .hdisp   (cfg_hdisp),
        .hblank  (cfg_hblank),
        .vlines  (cfg_vlines),
        .state   (state),
        .seg_cnt (seg_cnt),
        .vcnt    (vcnt)
    );

    pslcd_out #(
        .VD_W  (VD_W),
        .CNT_W (CNT_W),
        .PIX_W (PIX_W)
    ) u_out (
        .clk        (clk),
        .rst        (rst),
        .ts_en      (ts_en),
        .state      (state),
        .seg_cnt    (seg_cnt),
        .vcnt       (vcnt),
        .pix_data   (pix_data),
        .pix_valid  (pix_valid),
        .pix_ready  (pix_ready),
        .frame_q    (lcd_frame),
        .line_q     (lcd_line),
        .shift_q    (lcd_shift),
        .mod_q      (lcd_mod),
        .data_q     (data_q),
        .underrun_q (underrun)
    );

    assign lcd_dup = data_q[PIX_W-1:NIB_W];
    assign lcd_dlo = data_q[NIB_W-1:0];

endmodule

// File: tb/pslcd_timing_tb_top.sv
`timescale 1ns/1ps
module pslcd_timing_tb_top;

    localparam int WD_LIMIT = 190000;
    localparam int NVEC = 5;
    // {sel[25:24], hdisp[22:16], hblank[12:8], vlines[7:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {6'd0, 2'd0, 1'b0, 7'd0, 3'd0, 5'd3,  8'd1},
        {6'd0, 2'd1, 1'b0, 7'd2, 3'd0, 5'd5,  8'd2},
        {6'd0, 2'd2, 1'b0, 7'd1, 3'd0, 5'd0,  8'd1},
        {6'd0, 2'd3, 1'b0, 7'd3, 3'd0, 5'd4,  8'd1},
        {6'd0, 2'd1, 1'b0, 7'd0, 3'd0, 5'd31, 8'd1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_div_sel = '0;
    logic [6:0] cfg_hdisp = '0;
    logic [4:0] cfg_hblank = 5'd3;
    logic [8:0] cfg_vlines = 9'd1;
    logic [7:0] pix_data;
    logic       pix_valid = 1'b1;
    logic       pix_ready, lcd_frame, lcd_line, lcd_shift, lcd_mod, underrun;
    logic [3:0] lcd_dup, lcd_dlo;

    int checks = 0;
    int errors = 0;
    int tb_cyc = 0;
    int src = 0;
    bit chk_en = 1'b0;
    bit wd_hit = 1'b0;

    // monitor state
    int lp_rises, frame_rises, mod_edges, exp_rx;
    int t_lp_rise, t_lp_fall, t_sh_fall, t_sh_rise, t_fr_rise, t_mod;
    int per_line, lp_w, gap_fall_lp, sh_cnt, sh_last, rdy_cnt, rdy_last, sh_hw;
    int frame_w, frame_hold, frame_per, mod_lead;
    bit mod_pend, sh_in_lp, nz_seen;
    logic p_line, p_shift, p_frame, p_mod;
    logic [7:0] p_data;

    pslcd_timing dut_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_div_sel (cfg_div_sel),
        .cfg_hdisp   (cfg_hdisp),
        .cfg_hblank  (cfg_hblank),
        .cfg_vlines  (cfg_vlines),
        .pix_data    (pix_data),
        .pix_valid   (pix_valid),
        .pix_ready   (pix_ready),
        .lcd_frame   (lcd_frame),
        .lcd_line    (lcd_line),
        .lcd_shift   (lcd_shift),
        .lcd_mod     (lcd_mod),
        .lcd_dup     (lcd_dup),
        .lcd_dlo     (lcd_dlo),
        .underrun    (underrun)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] pat(input int n);
        return 8'(n * 37 + 5);
    endfunction

    assign pix_data = pat(src);

    always @(posedge clk) begin
        if (rst) src <= 0;
        else if (pix_valid && pix_ready) src <= src + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        tb_cyc++;
        if (rst) begin
            lp_rises = 0; frame_rises = 0; mod_edges = 0; exp_rx = 0;
            t_lp_rise = 0; t_lp_fall = 0; t_sh_fall = 0; t_sh_rise = 0;
            t_fr_rise = 0; t_mod = 0; per_line = 0; lp_w = 0; gap_fall_lp = 0;
            sh_cnt = 0; sh_last = 0; rdy_cnt = 0; rdy_last = 0; sh_hw = 0;
            frame_w = 0; frame_hold = 0; frame_per = 0; mod_lead = 0;
            mod_pend = 1'b0; sh_in_lp = 1'b0; nz_seen = 1'b0;
        end else begin
            if (pix_ready) rdy_cnt++;
            if (lcd_line && lcd_shift) sh_in_lp = 1'b1;
            if (lcd_shift && {lcd_dup, lcd_dlo} != 8'd0) nz_seen = 1'b1;
            if (lcd_line && !p_line) begin
                if (lp_rises > 0) per_line = tb_cyc - t_lp_rise;
                t_lp_rise = tb_cyc;
                lp_rises++;
                gap_fall_lp = tb_cyc - t_sh_fall;
                sh_last = sh_cnt; sh_cnt = 0;
                rdy_last = rdy_cnt; rdy_cnt = 0;
            end
            if (!lcd_line && p_line) begin
                t_lp_fall = tb_cyc;
                lp_w = tb_cyc - t_lp_rise;
                if (mod_pend) begin
                    mod_lead = tb_cyc - t_mod;
                    mod_pend = 1'b0;
                end
            end
            if (lcd_shift && !p_shift) begin
                sh_cnt++;
                t_sh_rise = tb_cyc;
            end
            if (!lcd_shift && p_shift) begin
                t_sh_fall = tb_cyc;
                sh_hw = tb_cyc - t_sh_rise;
                if (chk_en) begin
                    chk("R6 byte before fall", int'(p_data), int'(pat(exp_rx)));
                    chk("R6 byte after fall", int'({lcd_dup, lcd_dlo}), int'(pat(exp_rx)));
                    exp_rx++;
                end
            end
            if (lcd_frame && !p_frame) begin
                if (frame_rises > 0) frame_per = tb_cyc - t_fr_rise;
                t_fr_rise = tb_cyc;
                frame_rises++;
            end
            if (!lcd_frame && p_frame) begin
                frame_w = tb_cyc - t_fr_rise;
                frame_hold = tb_cyc - t_lp_fall;
            end
            if (lcd_mod != p_mod) begin
                mod_edges++;
                t_mod = tb_cyc;
                mod_pend = 1'b1;
            end
        end
        p_line = lcd_line; p_shift = lcd_shift; p_frame = lcd_frame;
        p_mod = lcd_mod; p_data = {lcd_dup, lcd_dlo};
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_lines(input int nl, input int nf);
        while ((lp_rises < nl || frame_rises < nf) && tb_cyc < WD_LIMIT) @(negedge clk);
        if (tb_cyc >= WD_LIMIT) wd_hit = 1'b1;
    endtask

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        chk("R10 frame in reset", int'(lcd_frame), 0);
        chk("R10 line in reset", int'(lcd_line), 0);
        chk("R10 shift in reset", int'(lcd_shift), 0);
        chk("R10 mod in reset", int'(lcd_mod), 0);
        chk("R10 data in reset", int'({lcd_dup, lcd_dlo}), 0);
        chk("R10 ready in reset", int'(pix_ready), 0);
        chk("R10 underrun in reset", int'(underrun), 0);

        for (int v = 0; v < NVEC; v++) begin
            int k, hd, hn, hne, vd, d, n, l;
            k  = int'(VEC[v][25:24]) + 1;
            hd = int'(VEC[v][22:16]);
            hn = int'(VEC[v][12:8]);
            vd = int'(VEC[v][7:0]);
            hne = (hn < 3) ? 3 : hn;
            d = (hd + 1) * 8;
            n = (hne + 1) * 8;
            l = d + n + 33;
            @(negedge clk);
            rst = 1'b1;
            cfg_div_sel = VEC[v][25:24];
            cfg_hdisp = VEC[v][22:16];
            cfg_hblank = VEC[v][12:8];
            cfg_vlines = 9'(vd);
            pix_valid = 1'b1;
            chk_en = 1'b1;
            repeat (4) @(negedge clk);
            rst = 1'b0;
            wait_lines(vd + 4, 2);
            // R2 and R3 (clamped entry) through the line period
            chk((hn < 3) ? "R3 clamped line period" : "R2 line period", per_line, l * k);
            chk("R4 line pulse width", lp_w, 9 * k);
            chk("R1 shift high width", sh_hw, k);
            chk("R5 shift rises per line", sh_last, (hd + 1) * 4);
            chk("R6 ready clocks per line", rdy_last, (hd + 1) * 4);
            chk("R5 last fall to pulse", gap_fall_lp, (n - 28) * k);
            chk("R5 shift idle in pulse", int'(sh_in_lp), 0);
            chk("R7 frame width", frame_w, l * k);
            chk("R7 frame after trailing edge", frame_hold, 14 * k);
            chk("R7 frame period", frame_per, (vd + 1) * l * k);
            chk("R8 mod lead", mod_lead, (d + n - 1) * k);
            chk("R8 mod once per frame", mod_edges, frame_rises);
        end

        // starvation
        chk_en = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        cfg_div_sel = 2'd0; cfg_hdisp = 7'd0; cfg_hblank = 5'd3; cfg_vlines = 9'd1;
        pix_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk("R9 underrun clear before data", int'(underrun), 0);
        wait_lines(2, 0);
        chk("R9 underrun set", int'(underrun), 1);
        chk("R9 zero data when starved", int'(nz_seen), 0);
        pix_valid = 1'b1;
        wait_lines(4, 0);
        chk("R9 underrun sticky", int'(underrun), 1);
        do_reset();
        chk("R10 underrun cleared", int'(underrun), 0);
        chk("R10 outputs low after reset", int'({lcd_frame, lcd_line, lcd_shift, lcd_mod}), 0);

        if (wd_hit) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected below %0d", tb_cyc, WD_LIMIT);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule